// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block caches page translations for 32-bit effective addresses. It holds 64 congruence classes of two entries each. An entry keeps a valid flag, a compare tag and a physical page number. The compare tag is built from a virtual segment identifier together with ten page-index bits of the effective address. Bits are counted with bit 0 as the most significant, so the page-index bits are bits 4 to 13, which are little-endian address bits [27:18]. The class is chosen by effective-address bits 14 to 19, which are little-endian bits [17:12].

The block has three ports. A lookup port reports hit or miss and the translated page number in the same cycle. A refill port writes a new translation after a miss. An invalidate port clears both entries of one class. Each class carries a single replacement bit. That bit names the entry to overwrite next. It moves away from an entry that has just hit or has just been written.

Reset clears only the replacement bits. Entry contents and valid flags keep their values through reset, so software must invalidate all 64 classes before it relies on lookups.

Top module: `tlb2w`

## Requirements
- R1: The class is selected by `ea[17:12]`. Address bits [31:28] and [11:0] play no part in selecting the class or in matching.
- R2: An entry matches only if it is valid and its stored tag equals `{vsid, ea[27:18]}`. A difference in any of those bits, including `ea[18]` or any vsid bit, gives a miss.
- R3: In the same cycle that `lk_req` is high, `lk_hit` reports a match in the indexed class and `lk_ppn` carries that entry's page number. `lk_ppn` is 0 on a miss.
- R4: After a lookup hits way w, the class's replacement bit names the other way (1-w).
- R5: A refill writes way 0 if way 0 is invalid. Otherwise it writes way 1 if way 1 is invalid. The replacement bit is consulted only when both ways are valid.
- R6: When both ways are valid, a refill overwrites the way named by the replacement bit. Afterwards the bit names the way that was not written.
- R7: An invalidate clears both ways of the class selected by `inv_ea[17:12]` and leaves every other class untouched.
- R8: If an invalidate and a refill select the same class in one cycle, the refill is dropped and that class ends with both ways invalid.
- R9: Reset sets every replacement bit to 0, which names way 0. Reset keeps valid flags, tags and page numbers unchanged.
- R10: If a refill and a hitting lookup select the same class in one cycle, the refill's update of the replacement bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Lookup effective address |
| lk_vsid | input | 24 | Lookup virtual segment identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Translated physical page number |
| fl_req | input | 1 | Refill request |
| fl_ea | input | 32 | Refill effective address |
| fl_vsid | input | 24 | Refill virtual segment identifier |
| fl_ppn | input | 20 | Refill physical page number |
| inv_req | input | 1 | Class invalidate request |
| inv_ea | input | 32 | Effective address selecting the class to invalidate |

## Verification
The assertions assume that a class never holds two valid entries with the same tag, so that at most one way can match a lookup. That holds when refills only follow misses. The stimulus keeps this assumption: before every refill the bench searches its model of the target class and skips the refill if the tag is already present. The assertions also assume that lookups run only after the post-reset invalidate sweep. The bench compares no outputs until all 64 classes have been invalidated.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;
    localparam int EA_W    = 32;
    localparam int VSID_W  = 24;
    localparam int PPN_W   = 20;
    localparam int IDX_W   = 6;
    localparam int IDX_LSB = 12;
    localparam int PI_W    = 10;
    localparam int PI_LSB  = IDX_LSB + IDX_W;
    localparam int SETS    = 1 << IDX_W;
    localparam int WAYS    = 2;
    localparam int TAG_W   = VSID_W + PI_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [PPN_W-1:0]  ppn_t;
    typedef logic [VSID_W-1:0] vsid_t;

    typedef enum logic {WAY0 = 1'b0, WAY1 = 1'b1} way_e;

    typedef struct packed {
        logic vld;
        tag_t tag;
        ppn_t ppn;
    } entry_t;

    function automatic tag_t make_tag(input vsid_t vsid, input logic [PI_W-1:0] pi);
        return {vsid, pi};
    endfunction

    // Invalid ways are taken first, the replacement bit only when both are valid.
    function automatic way_e pick_victim(input logic v0, input logic v1, input logic repl);
        if (!v0)      return WAY0;
        else if (!v1) return WAY1;
        else          return way_e'(repl);
    endfunction
endpackage

// File: rtl/tlb2w_way_store.sv
module tlb2w_way_store
    import tlb2w_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  tag_t   wr_tag,
    input  ppn_t   wr_ppn,
    input  logic   clr_en,
    input  idx_t   clr_idx,
    input  idx_t   lk_idx,
    output entry_t lk_ent,
    input  idx_t   fl_idx,
    output logic   fl_vld
);
    logic vld_q [SETS];
    tag_t tag_q [SETS];
    ppn_t ppn_q [SETS];

    // No reset on the arrays: contents survive reset by intent.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            tag_q[wr_idx] <= wr_tag;
            ppn_q[wr_idx] <= wr_ppn;
        end
        if (clr_en) begin
            vld_q[clr_idx] <= 1'b0;
        end
    end

    assign lk_ent = '{vld: vld_q[lk_idx], tag: tag_q[lk_idx], ppn: ppn_q[lk_idx]};
    assign fl_vld = vld_q[fl_idx];

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !vld_q[$past(clr_idx)]);

    assert_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(clr_en && clr_idx == wr_idx)) |=>
            (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
             && ppn_q[$past(wr_idx)] == $past(wr_ppn)));
endmodule

// File: rtl/tlb2w_lru.sv
module tlb2w_lru
    import tlb2w_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_en,
    input  idx_t a_idx,
    input  logic a_val,
    input  logic b_en,
    input  idx_t b_idx,
    input  logic b_val,
    input  idx_t rd_idx,
    output logic rd_val
);
    logic [SETS-1:0] repl_q;

    // Port a (refill) has priority over port b (hit) on the same class.
    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst)
                repl_q[s] <= 1'b0;
            else if (a_en && a_idx == idx_t'(s))
                repl_q[s] <= a_val;
            else if (b_en && b_idx == idx_t'(s))
                repl_q[s] <= b_val;
        end
    end

    assign rd_val = repl_q[rd_idx];

    assert_repl_reset_R9: assert property (@(posedge clk)
        rst |=> (repl_q == '0));

    assert_fill_beats_hit_R10: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && a_idx == b_idx) |=> (repl_q[$past(a_idx)] == $past(a_val)));

    assert_hit_update_R4: assert property (@(posedge clk) disable iff (rst)
        (b_en && !(a_en && a_idx == b_idx)) |=> (repl_q[$past(b_idx)] == $past(b_val)));
endmodule

// File: rtl/tlb2w.sv
module tlb2w
    import tlb2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [EA_W-1:0]   lk_ea,
    input  logic [VSID_W-1:0] lk_vsid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              fl_req,
    input  logic [EA_W-1:0]   fl_ea,
    input  logic [VSID_W-1:0] fl_vsid,
    input  logic [PPN_W-1:0]  fl_ppn,
    input  logic              inv_req,
    input  logic [EA_W-1:0]   inv_ea
);
    idx_t lk_idx, fl_idx, inv_idx;
    tag_t lk_tag, fl_tag;

    assign lk_idx  = lk_ea[IDX_LSB +: IDX_W];
    assign fl_idx  = fl_ea[IDX_LSB +: IDX_W];
    assign inv_idx = inv_ea[IDX_LSB +: IDX_W];
    assign lk_tag  = make_tag(lk_vsid, lk_ea[PI_LSB +: PI_W]);
    assign fl_tag  = make_tag(fl_vsid, fl_ea[PI_LSB +: PI_W]);

    logic unused_ea_bits;
    assign unused_ea_bits = ^{lk_ea[EA_W-1:PI_LSB+PI_W], lk_ea[IDX_LSB-1:0],
                              fl_ea[EA_W-1:PI_LSB+PI_W], fl_ea[IDX_LSB-1:0],
                              inv_ea[EA_W-1:IDX_LSB+IDX_W], inv_ea[IDX_LSB-1:0]};

    logic fill_go, clr_go, repl_fill;
    way_e victim, hit_way;
    entry_t lk_ent [WAYS];
    logic   fl_vld [WAYS];
    logic [WAYS-1:0] match;

    // An invalidate of the same class drops the refill entirely.
    assign fill_go = fl_req && !rst && !(inv_req && inv_idx == fl_idx);
    assign clr_go  = inv_req && !rst;
    assign victim  = pick_victim(fl_vld[0], fl_vld[1], repl_fill);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb2w_way_store u_store (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (fill_go && (victim == way_e'(w))),
            .wr_idx  (fl_idx),
            .wr_tag  (fl_tag),
            .wr_ppn  (fl_ppn),
            .clr_en  (clr_go),
            .clr_idx (inv_idx),
            .lk_idx  (lk_idx),
            .lk_ent  (lk_ent[w]),
            .fl_idx  (fl_idx),
            .fl_vld  (fl_vld[w])
        );
        assign match[w] = lk_req && lk_ent[w].vld && (lk_ent[w].tag == lk_tag);
    end

    assign hit_way = match[0] ? WAY0 : WAY1;
    assign lk_hit  = |match;
    assign lk_ppn  = match[0] ? lk_ent[0].ppn : (match[1] ? lk_ent[1].ppn : '0);

    tlb2w_lru u_lru (
        .clk    (clk),
        .rst    (rst),
        .a_en   (fill_go),
        .a_idx  (fl_idx),
        .a_val  (victim == WAY0),
        .b_en   (lk_hit),
        .b_idx  (lk_idx),
        .b_val  (hit_way == WAY0),
        .rd_idx (fl_idx),
        .rd_val (repl_fill)
    );

    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> $onehot0(match));

    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_ppn == '0));
endmodule

// File: tb/tb_tlb2w.sv
`timescale 1ns/1ps
module tb_tlb2w;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 0, fl_req = 0, inv_req = 0;
    logic [31:0] lk_ea = 0, fl_ea = 0, inv_ea = 0;
    logic [23:0] lk_vsid = 0, fl_vsid = 0;
    logic [19:0] fl_ppn = 0;
    logic        lk_hit;
    logic [19:0] lk_ppn;

    always #5 clk = ~clk;

    tlb2w dut (.*);

    int checks = 0, errors = 0;
    bit model_ok = 0;
    bit finished = 0;

    // Behavioural reference: per class two slots and a replacement bit.
    bit          mv [64][2];
    logic [33:0] mt [64][2];
    logic [19:0] mp [64][2];
    bit   [63:0] ml;

    function automatic logic [31:0] mk_ea(int idx, int pi, int junk);
        return {4'(junk), 10'(pi), 6'(idx), 12'(junk * 37)};
    endfunction

    function automatic void mlook(logic [31:0] ea, logic [23:0] vs, output bit h,
                                  output logic [19:0] p, output int w);
        int i = int'(ea[17:12]);
        h = 0; p = '0; w = 0;
        for (int k = 1; k >= 0; k--)
            if (mv[i][k] && mt[i][k] == {vs, ea[27:18]}) begin h = 1; p = mp[i][k]; w = k; end
    endfunction

    task automatic report(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(string req);
        bit eh; logic [19:0] ep; int ew;
        #1;
        if (model_ok && !rst) begin
            mlook(lk_ea, lk_vsid, eh, ep, ew);
            if (!lk_req) begin eh = 0; ep = '0; end
            report(lk_hit == eh, req, "model hit", 32'(lk_hit), 32'(eh));
            report(lk_ppn == ep, req, "model ppn", 32'(lk_ppn), 32'(ep));
        end
        @(posedge clk);
        if (rst) ml = '0;
        else begin
            int li = int'(lk_ea[17:12]);
            int fi = int'(fl_ea[17:12]);
            int ii = int'(inv_ea[17:12]);
            bit fgo = fl_req && !(inv_req && ii == fi);
            bit lh; logic [19:0] lp; int lw;
            int vic;
            mlook(lk_ea, lk_vsid, lh, lp, lw);
            vic = !mv[fi][0] ? 0 : (!mv[fi][1] ? 1 : int'(ml[fi]));
            if (lk_req && lh && !(fgo && fi == li)) ml[li] = (lw == 0);
            if (fgo) begin
                mv[fi][vic] = 1; mt[fi][vic] = {fl_vsid, fl_ea[27:18]}; mp[fi][vic] = fl_ppn;
                ml[fi] = (vic == 0);
            end
            if (inv_req) begin mv[ii][0] = 0; mv[ii][1] = 0; end
        end
        @(negedge clk);
        lk_req = 0; fl_req = 0; inv_req = 0;
    endtask

    task automatic fill(int idx, int pi, logic [23:0] vs, logic [19:0] ppn, string req);
        fl_req = 1; fl_ea = mk_ea(idx, pi, 3); fl_vsid = vs; fl_ppn = ppn;
        step(req);
    endtask

    task automatic look(logic [31:0] ea, logic [23:0] vs, bit eh, logic [19:0] ep, string req);
        lk_req = 1; lk_ea = ea; lk_vsid = vs;
        #1;
        report(lk_hit == eh, req, "hit", 32'(lk_hit), 32'(eh));
        report(lk_ppn == ep, req, "ppn", 32'(lk_ppn), 32'(ep));
        lk_req = 1;
        step(req);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        ml = '0;
        @(negedge clk);
        rst = 1; step("R9"); step("R9"); step("R9");
        rst = 0;
        for (int s = 0; s < 64; s++) begin inv_req = 1; inv_ea = mk_ea(s, 5, s); step("R7"); end
        model_ok = 1;

        // R9 + R5: reset keeps way 0, replacement bit returns to 0, invalid way 1 still chosen
        fill(9, 1, 24'h1, 20'hA0001, "R5");
        rst = 1; step("R9"); rst = 0;
        look(mk_ea(9, 1, 7), 24'h1, 1, 20'hA0001, "R9");
        fill(9, 2, 24'h1, 20'hA0002, "R5");
        look(mk_ea(9, 1, 2), 24'h1, 1, 20'hA0001, "R5");
        look(mk_ea(9, 2, 2), 24'h1, 1, 20'hA0002, "R5");

        // R4 / R6: LRU victim once both ways are valid
        fill(5, 1, 24'h2, 20'h11111, "R5");
        fill(5, 2, 24'h2, 20'h22222, "R5");
        look(mk_ea(5, 1, 0), 24'h2, 1, 20'h11111, "R4");
        fill(5, 3, 24'h2, 20'h33333, "R6");
        look(mk_ea(5, 1, 0), 24'h2, 1, 20'h11111, "R6");
        look(mk_ea(5, 2, 0), 24'h2, 0, 20'h0, "R6");
        look(mk_ea(5, 3, 0), 24'h2, 1, 20'h33333, "R6");
        fill(5, 4, 24'h2, 20'h44444, "R6");
        look(mk_ea(5, 3, 9), 24'h2, 1, 20'h33333, "R4");
        look(mk_ea(5, 1, 0), 24'h2, 0, 20'h0, "R6");
        look(mk_ea(5, 4, 0), 24'h2, 1, 20'h44444, "R6");

        // R1 / R2: index and tag fields
        look(mk_ea(5, 4, 15), 24'h2, 1, 20'h44444, "R1");
        look(mk_ea(6, 4, 0), 24'h2, 0, 20'h0, "R1");
        look(mk_ea(5, 4 ^ 1, 0), 24'h2, 0, 20'h0, "R2");
        look(mk_ea(5, 4 ^ 512, 0), 24'h2, 0, 20'h0, "R2");
        look(mk_ea(5, 4, 0), 24'h800002, 0, 20'h0, "R2");
        lk_req = 0; lk_ea = mk_ea(5, 4, 0); lk_vsid = 24'h2;
        #1; report(lk_hit == 0 && lk_ppn == 0, "R3", "idle", 32'(lk_ppn), 0);
        step("R3");

        // R7: class clear, neighbours kept
        inv_req = 1; inv_ea = mk_ea(5, 77, 11); step("R7");
        look(mk_ea(5, 3, 0), 24'h2, 0, 20'h0, "R7");
        look(mk_ea(5, 4, 0), 24'h2, 0, 20'h0, "R7");
        look(mk_ea(9, 2, 0), 24'h1, 1, 20'hA0002, "R7");

        // R8: invalidate beats refill on same class; different class both proceed
        fill(7, 8, 24'h3, 20'h77777, "R8");
        fl_req = 1; fl_ea = mk_ea(7, 9, 0); fl_vsid = 24'h3; fl_ppn = 20'h78888;
        inv_req = 1; inv_ea = mk_ea(7, 0, 1); step("R8");
        look(mk_ea(7, 9, 0), 24'h3, 0, 20'h0, "R8");
        look(mk_ea(7, 8, 0), 24'h3, 0, 20'h0, "R8");
        fl_req = 1; fl_ea = mk_ea(8, 9, 0); fl_vsid = 24'h3; fl_ppn = 20'h89999;
        inv_req = 1; inv_ea = mk_ea(7, 0, 1); step("R8");
        look(mk_ea(8, 9, 0), 24'h3, 1, 20'h89999, "R8");

        // R10: refill and hit on same class, refill's replacement update wins
        fill(3, 1, 24'h4, 20'h31111, "R10");
        fill(3, 2, 24'h4, 20'h32222, "R10");
        lk_req = 1; lk_ea = mk_ea(3, 2, 0); lk_vsid = 24'h4;
        fl_req = 1; fl_ea = mk_ea(3, 3, 0); fl_vsid = 24'h4; fl_ppn = 20'h33333;
        #1; report(lk_hit == 1, "R10", "hit", 32'(lk_hit), 1);
        step("R10");
        fill(3, 4, 24'h4, 20'h34444, "R10");
        look(mk_ea(3, 2, 0), 24'h4, 0, 20'h0, "R10");
        look(mk_ea(3, 3, 0), 24'h4, 1, 20'h33333, "R10");
        look(mk_ea(3, 4, 0), 24'h4, 1, 20'h34444, "R10");

        // Mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            lk_req = ($urandom_range(0, 3) != 0);
            lk_ea = mk_ea(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), n);
            lk_vsid = 24'($urandom_range(0, 1));
            if (r < 40) begin
                bit eh; logic [19:0] ep; int ew;
                fl_ea = mk_ea(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), n + 1);
                fl_vsid = 24'($urandom_range(0, 1));
                fl_ppn = 20'($urandom);
                mlook(fl_ea, fl_vsid, eh, ep, ew);
                fl_req = !eh;
            end
            if (r >= 90) begin inv_req = 1; inv_ea = mk_ea(int'($urandom_range(0, 3)), 0, n); end
            if (n % 997 == 500) rst = 1;
            step("R6");
            rst = 0;
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule